// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a row of boundary scan cells that sits between a chip's pins and its core logic. Every cell holds two flip-flops. The first is a capture/shift stage. It either snapshots the pin-side value or takes the serial bit from its upstream neighbour. The second is an update stage, loaded from the first on command. A per-cell output mux feeds the core side. It passes either the live pin value or the held update value.

An external test-access controller drives the chain through four controls. One selects shifting over capturing. One enables the capture/shift stage. One enables the update stage. The last selects test over normal output. With these controls, software can sample all pins without disturbing normal operation. It can also preload a pattern before test mode is entered, or drive test values onto the core side. New bits can be shifted through the chain while test mode is active, and the driven values do not move until the next update.

All stages use the rising edge of the test clock and a synchronous active-low reset. The chain length is a parameter.

Top module: `bsc_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, every capture and update stage clears to 0. After that edge `scan_out` reads 0, and with `test_mode`=1 `core_out` reads all zeros.
- R2: At an edge with `capture_en`=1 and `shift_en`=0, cell i loads `pin_in[i]`.
- R3: At an edge with `capture_en`=1 and `shift_en`=1, cell 0 loads `scan_in`, cell i loads the old value of cell i-1, and `scan_out` shows cell CHAIN_LEN-1. A bit entered at `scan_in` reaches `scan_out` after exactly CHAIN_LEN shift edges.
- R4: At an edge with `capture_en`=0, the capture/shift stages keep their values whatever `shift_en`, `scan_in` and `pin_in` are.
- R5: At an edge with `update_en`=1, every update stage takes the value its capture/shift stage held before that edge. With `test_mode`=1, `core_out[i]` then shows update stage i.
- R6: With `update_en`=0, the update stages hold their values. Capturing or shifting in test mode leaves `core_out` unchanged.
- R7: With `test_mode`=0, `core_out` equals `pin_in` in the same cycle, whatever the state of the chain.
- R8: A capture done with `test_mode`=0 (sample) records the pins while `core_out` keeps following `pin_in`.
- R9: Values shifted in and updated while `test_mode`=0 (preload) appear on `core_out` as soon as `test_mode` goes to 1, with no further edge needed.
- R10: When `capture_en` and `update_en` are both 1 at the same edge, the update stages receive the values captured before that edge. The newly captured values reach the update stages only at a later update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all stages use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_in | input | 1 | Serial input into cell 0 |
| shift_en | input | 1 | 1 = shift from neighbour, 0 = capture pin |
| capture_en | input | 1 | Enables the capture/shift stages |
| update_en | input | 1 | Enables the update stages |
| test_mode | input | 1 | 1 = core side driven by update stages, 0 = by pins |
| pin_in | input | CHAIN_LEN | Pin-side value of each cell |
| core_out | output | CHAIN_LEN | Core-side value of each cell |
| scan_out | output | 1 | Serial output from cell CHAIN_LEN-1 |

## Verification
Register results (capture, shift, update and reset) are due one edge after the controls are applied. The bench therefore drives inputs on the falling edge and samples 1 ns after the next rising edge, while the same inputs are still applied. `core_out` in normal mode is combinational, and a `test_mode` change takes effect in the same cycle, so those values are checked at that same sample point without waiting for an extra edge. The full-length shift test counts edges one by one and expects the marker bit at `scan_out` on edge CHAIN_LEN and not before.

// File: rtl/bsc_pkg.sv
// Shared types for the boundary scan cell chain.
package bsc_pkg;
    // Selects what drives the core side of a cell.
    typedef enum logic {
        OUT_NORMAL = 1'b0,
        OUT_TEST   = 1'b1
    } bsc_mode_e;
endpackage

// File: rtl/bsc_capture_stage.sv
// Capture/shift flip-flop of one cell.
// Loads the pin value or the upstream serial bit when enabled.
// Assumes a single test clock and a synchronous active-low reset.
module bsc_capture_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic pin,
    input  logic serial_prev,
    output logic q
);
    logic d_sel;

    // Choose between the pin snapshot and the serial path.
    always_comb begin
        d_sel = shift_en ? serial_prev : pin;
    end

    // Register the selected bit when capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (cap_en) q <= d_sel;
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q));
    // R2
    capture_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !shift_en) |=> (q == $past(pin)));
    // R3
    shift_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && shift_en) |=> (q == $past(serial_prev)));
endmodule

// File: rtl/bsc_update_stage.sv
// Update flip-flop of one cell: copies the capture stage when enabled.
// Assumes the capture stage is clocked by the same edge.
module bsc_update_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic d,
    output logic q
);
    // Copy the capture value on an update edge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (upd_en) q <= d;
    end

    // R5
    update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (q == $past(d)));
    // R6
    update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(q));
endmodule

// File: rtl/bsc_out_mux.sv
// Core-side output selector of one cell.
// Assumes mode is a static control from the test-access controller.
module bsc_out_mux
    import bsc_pkg::*;
(
    input  bsc_mode_e mode,
    input  logic      pin,
    input  logic      held,
    output logic      core
);
    // Pass the pin in normal mode, the update stage in test mode.
    always_comb begin
        core = (mode == OUT_TEST) ? held : pin;
    end
endmodule

// File: rtl/bsc_chain.sv
// Parameterised chain of boundary scan cells.
// Cell 0 sits next to scan_in; cell CHAIN_LEN-1 drives scan_out.
// Assumes all controls are synchronous to clk and come from a TAP controller.
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_in,
    input  logic                 shift_en,
    input  logic                 capture_en,
    input  logic                 update_en,
    input  logic                 test_mode,
    input  logic [CHAIN_LEN-1:0] pin_in,
    output logic [CHAIN_LEN-1:0] core_out,
    output logic                 scan_out
);
    localparam int LAST = CHAIN_LEN - 1;

    logic [CHAIN_LEN:0]   link;
    logic [CHAIN_LEN-1:0] cap_q;
    logic [CHAIN_LEN-1:0] upd_q;
    bsc_mode_e            mode;

    // Decode the mode control once for all cells.
    always_comb begin
        mode = bsc_mode_e'(test_mode);
    end

    assign link[0] = scan_in;
    assign scan_out = link[CHAIN_LEN];

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        bsc_capture_stage u_cap (
            .clk         (clk),
            .rst_n       (rst_n),
            .cap_en      (capture_en),
            .shift_en    (shift_en),
            .pin         (pin_in[i]),
            .serial_prev (link[i]),
            .q           (cap_q[i])
        );
        assign link[i+1] = cap_q[i];

        bsc_update_stage u_upd (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_en (update_en),
            .d      (cap_q[i]),
            .q      (upd_q[i])
        );

        bsc_out_mux u_mux (
            .mode (mode),
            .pin  (pin_in[i]),
            .held (upd_q[i]),
            .core (core_out[i])
        );
    end

    // R3
    tail_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (scan_out == cap_q[LAST]) && (link[0] == scan_in));
    // R10
    upd_gets_old_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && update_en) |=> (upd_q == $past(cap_q)));
endmodule

// File: tb/sim_bsc_chain.sv
module sim_bsc_chain;
    localparam int N = 8;
    // Row: [21]sh [20]ce [19]ue [18]tm [17]si [16:9]pin [8]exp_so [7:0]exp_core
    localparam int ROWS = 12;
    localparam logic [21:0] VECS [0:ROWS-1] = '{
        {1'b0,1'b1,1'b0,1'b0,1'b0,8'hA5,1'b1,8'hA5}, // R2 R8 sample
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,1'b1,8'h00}, // R4 R7 hold
        {1'b1,1'b1,1'b0,1'b0,1'b0,8'hFF,1'b0,8'hFF}, // R3 shift -> 4A
        {1'b1,1'b1,1'b0,1'b0,1'b1,8'h3C,1'b1,8'h3C}, // R3 shift -> 95
        {1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,8'h95}, // R5 update
        {1'b1,1'b1,1'b0,1'b1,1'b0,8'h0F,1'b0,8'h95}, // R6 shift in test -> 2A
        {1'b0,1'b0,1'b0,1'b0,1'b0,8'h77,1'b0,8'h77}, // R7 normal
        {1'b0,1'b1,1'b0,1'b1,1'b0,8'hC3,1'b1,8'h95}, // R6 capture in test
        {1'b0,1'b0,1'b1,1'b0,1'b0,8'h11,1'b1,8'h11}, // R9 preload update
        {1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b1,8'hC3}, // R9 enter test
        {1'b0,1'b1,1'b1,1'b1,1'b0,8'h5A,1'b0,8'hC3}, // R10 both enables
        {1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,8'h5A}  // R10 later update
    };
    localparam string TAGS [0:ROWS-1] = '{"R2","R4","R3","R3","R5","R6",
                                          "R7","R6","R9","R9","R10","R10"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0;
    logic update_en = 1'b0, test_mode = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] core_out;
    logic scan_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bsc_chain #(.CHAIN_LEN(N)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .test_mode(test_mode),
        .pin_in(pin_in), .core_out(core_out), .scan_out(scan_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic sh, ce, ue, tm, si, input logic [N-1:0] pin);
        @(negedge clk);
        shift_en = sh; capture_en = ce; update_en = ue;
        test_mode = tm; scan_in = si; pin_in = pin;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state, test mode shows cleared update stages
        test_mode = 1'b1; pin_in = 8'hFF; capture_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", {7'b0, scan_out}, 8'h00);
        check("R1", core_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            drive(VECS[r][21], VECS[r][20], VECS[r][19], VECS[r][18],
                  VECS[r][17], VECS[r][16:9]);
            check(TAGS[r], {7'b0, scan_out}, {7'b0, VECS[r][8]});
            check(TAGS[r], core_out, VECS[r][7:0]);
        end

        // R1: reset mid-operation clears both stages
        @(negedge clk);
        rst_n = 1'b0; capture_en = 1'b1; update_en = 1'b1; shift_en = 1'b0;
        pin_in = 8'hFF; test_mode = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {7'b0, scan_out}, 8'h00);
        check("R1", core_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1; capture_en = 1'b0; update_en = 1'b0;

        // R3: marker bit reaches scan_out after exactly N shifts
        for (int k = 1; k <= N; k++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, (k == 1), 8'hFF);
            check("R3", {7'b0, scan_out}, {7'b0, (k == N)});
        end

        // R4: shift_en alone with capture off keeps the marker
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R4", {7'b0, scan_out}, 8'h01);

        // R7: normal mode follows pins in the same cycle
        @(negedge clk);
        test_mode = 1'b0; capture_en = 1'b0; update_en = 1'b0;
        pin_in = 8'h6E;
        #1;
        check("R7", core_out, 8'h6E);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule